// File: doc/BRIEF.md
# Addressable RGB LED Chain Driver

This block drives a daisy chain of single-wire addressable RGB LEDs from one serial output. It runs continuously from the system clock. The default build assumes a 100 MHz clock and eight LEDs. Each LED's 24-bit colour word is an input.

Each bit goes out as a fixed-length pulse. The pulse's high time encodes the bit value. After the last LED's word, the line stays low long enough for the chain to latch, and then the frame starts again at the first LED. Every LED takes its own 24 bits and passes any later bits along the chain. The low gap therefore returns the chain to its first LED.

Timing comes from three nested counters and nothing else:
- a cycle counter inside one bit;
- a bit counter inside one 24-bit word;
- a slot counter over the LEDs plus two trailing all-low slots.

The trailing slots provide the latch gap, so no separate timer is needed.

Top module: `ledchain_driver`

## Requirements
- R1: Every bit occupies exactly BIT_CYCLES clock cycles (125 by default). A one bit is high for the first ONE_HIGH cycles (80 by default) and low for the rest of its window.
- R2: A zero bit is high for the first ZERO_HIGH cycles (40 by default) and low for the rest of its window.
- R3: Each LED word is 24 bits wide. Bits [23:16] hold green, [15:8] hold red and [7:0] hold blue. The word is sent from bit 23 down to bit 0, so the byte order is green, red, blue, each byte most significant bit first.
- R4: The word for LED i is taken from `ledWords[24*i +: 24]`. LEDs are sent in order i = 0, 1, ..., NUM_LEDS-1.
- R5: After the last LED's word, the output is low for RESET_SLOTS slots of 24 bit windows each. With the defaults this is 2 × 30 µs, a gap longer than 50 µs.
- R6: After the reset slots, the frame repeats from LED 0, bit 23, without end.
- R7: An LED's word is sampled at the first cycle of its slot. A change to that word during its slot does not alter the bits being sent.
- R8: While the synchronous active-high `rst` is asserted, the output is low after the first clock edge. On release, transmission restarts at LED 0, bit 23, with its first high cycle on the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ledWords | input | NUM_LEDS*24 | Packed colour words, LED i in bits [24*i+23:24*i] |
| serialOut | output | 1 | Single-wire data line to the LED chain |

## Verification
The bench builds the driver with three LEDs, a 10-cycle bit window, a zero-bit high time of 3 cycles and a one-bit high time of 7 cycles. The reset gap stays at two slots. With these values a full frame is 1200 cycles. Many frames therefore fit in one run, including frame repeats, a reset asserted in the middle of a frame, and input changes in the middle of a slot. The pulse shapes, the byte order and the gap length are still checked cycle by cycle against a bench model of the waveform.

// File: rtl/ledchain_pkg.sv
package ledchain_pkg;
  // Strobes from the counter control to the waveform datapath
  typedef struct packed {
    logic loadWord;   // first cycle of a slot: capture the next colour word
    logic shiftBit;   // last cycle of a bit window: advance to the next bit
    logic dataSlot;   // current slot carries colour data (not the latch gap)
  } chainStrobe_t;
endpackage

// File: rtl/ledchain_ctrl.sv
module ledchain_ctrl
  import ledchain_pkg::*;
#(
  parameter int NUM_LEDS    = 8,
  parameter int RESET_SLOTS = 2,
  parameter int BIT_CYCLES  = 125,
  parameter int WORD_BITS   = 24,
  localparam int TOTAL_SLOTS = NUM_LEDS + RESET_SLOTS,
  localparam int CYC_W  = $clog2(BIT_CYCLES),
  localparam int BIT_W  = $clog2(WORD_BITS),
  localparam int SLOT_W = $clog2(TOTAL_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  output chainStrobe_t      strobe,
  output logic [CYC_W-1:0]  cycleIdx,
  output logic [SLOT_W-1:0] slotIdx
);
  logic [CYC_W-1:0]  cycleCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic cycWrap, bitWrap, slotWrap;

  assign cycWrap  = (cycleCnt == CYC_W'(BIT_CYCLES - 1));
  assign bitWrap  = cycWrap && (bitCnt == BIT_W'(WORD_BITS - 1));
  assign slotWrap = bitWrap && (slotCnt == SLOT_W'(TOTAL_SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cycleCnt <= '0;
      bitCnt   <= '0;
      slotCnt  <= '0;
    end else begin
      cycleCnt <= cycWrap ? '0 : cycleCnt + 1'b1;
      if (cycWrap) bitCnt <= bitWrap ? '0 : bitCnt + 1'b1;
      if (bitWrap) slotCnt <= slotWrap ? '0 : slotCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.loadWord = (cycleCnt == '0) && (bitCnt == '0);
    strobe.shiftBit = cycWrap;
    strobe.dataSlot = (slotCnt < SLOT_W'(NUM_LEDS));
  end

  assign cycleIdx = cycleCnt;
  assign slotIdx  = slotCnt;
endmodule

// File: rtl/ledchain_dp.sv
module ledchain_dp
  import ledchain_pkg::*;
#(
  parameter int NUM_LEDS   = 8,
  parameter int WORD_BITS  = 24,
  parameter int BIT_CYCLES = 125,
  parameter int ZERO_HIGH  = 40,
  parameter int ONE_HIGH   = 80,
  parameter int CYC_W      = 7,
  parameter int SLOT_W     = 4,
  localparam int CMP_W = CYC_W + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  chainStrobe_t                  strobe,
  input  logic [CYC_W-1:0]              cycleIdx,
  input  logic [SLOT_W-1:0]             slotIdx,
  input  logic [NUM_LEDS*WORD_BITS-1:0] ledWords,
  output logic                          serialOut
);
  logic [WORD_BITS-1:0] wordArr [NUM_LEDS];
  logic [WORD_BITS-1:0] selWord;
  logic [WORD_BITS-1:0] shiftReg;
  logic                 curBit;
  logic [CMP_W-1:0]     highLen;

  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_unpack
    assign wordArr[g] = ledWords[g*WORD_BITS +: WORD_BITS];
  end

  always_comb begin
    selWord = '0;
    for (int i = 0; i < NUM_LEDS; i++)
      if (slotIdx == SLOT_W'(i)) selWord = wordArr[i];
  end

  // On the load cycle the bit comes straight from the word being captured
  assign curBit  = strobe.loadWord ? selWord[WORD_BITS-1] : shiftReg[WORD_BITS-1];
  assign highLen = curBit ? CMP_W'(ONE_HIGH) : CMP_W'(ZERO_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg  <= '0;
      serialOut <= 1'b0;
    end else begin
      if (strobe.loadWord)      shiftReg <= selWord;
      else if (strobe.shiftBit) shiftReg <= {shiftReg[WORD_BITS-2:0], 1'b0};
      serialOut <= strobe.dataSlot && ({1'b0, cycleIdx} < highLen);
    end
  end
endmodule

// File: rtl/ledchain_driver.sv
module ledchain_driver
  import ledchain_pkg::*;
#(
  parameter int NUM_LEDS    = 8,
  parameter int RESET_SLOTS = 2,
  parameter int COLOR_BITS  = 8,
  parameter int BIT_CYCLES  = 125,
  parameter int ZERO_HIGH   = 40,
  parameter int ONE_HIGH    = 80,
  localparam int WORD_BITS   = 3 * COLOR_BITS,
  localparam int TOTAL_SLOTS = NUM_LEDS + RESET_SLOTS,
  localparam int CYC_W  = $clog2(BIT_CYCLES),
  localparam int SLOT_W = $clog2(TOTAL_SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_LEDS*WORD_BITS-1:0] ledWords,
  output logic                          serialOut
);
  chainStrobe_t      strobe;
  logic [CYC_W-1:0]  cycleIdx;
  logic [SLOT_W-1:0] slotIdx;

  ledchain_ctrl #(
    .NUM_LEDS(NUM_LEDS), .RESET_SLOTS(RESET_SLOTS),
    .BIT_CYCLES(BIT_CYCLES), .WORD_BITS(WORD_BITS)
  ) ctrl_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .cycleIdx(cycleIdx), .slotIdx(slotIdx)
  );

  ledchain_dp #(
    .NUM_LEDS(NUM_LEDS), .WORD_BITS(WORD_BITS), .BIT_CYCLES(BIT_CYCLES),
    .ZERO_HIGH(ZERO_HIGH), .ONE_HIGH(ONE_HIGH),
    .CYC_W(CYC_W), .SLOT_W(SLOT_W)
  ) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .cycleIdx(cycleIdx),
    .slotIdx(slotIdx), .ledWords(ledWords), .serialOut(serialOut)
  );
endmodule

// File: rtl/ledchain_checker.sv
module ledchain_checker #(
  parameter int NUM_LEDS    = 8,
  parameter int RESET_SLOTS = 2,
  parameter int WORD_BITS   = 24,
  parameter int BIT_CYCLES  = 125,
  parameter int ZERO_HIGH   = 40,
  parameter int ONE_HIGH    = 80,
  parameter int SLOT_W      = 4,
  localparam int MAX_LOW = (BIT_CYCLES - ZERO_HIGH) + RESET_SLOTS * WORD_BITS * BIT_CYCLES
) (
  input logic              clk,
  input logic              rst,
  input logic              serialOut,
  input logic [SLOT_W-1:0] slotIdx
);
  logic [31:0] highRun, lowRun;
  logic        armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      highRun <= '0;
      lowRun  <= '0;
      armed   <= 1'b1;
    end else begin
      highRun <= serialOut ? highRun + 1 : '0;
      lowRun  <= serialOut ? '0 : lowRun + 1;
    end
  end

  AST_RST_LOW: assert property (@(posedge clk) rst |=> !serialOut); // R8

  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    serialOut |-> (highRun < 32'(ONE_HIGH))); // R1

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    $fell(serialOut) |-> (highRun == 32'(ZERO_HIGH) || highRun == 32'(ONE_HIGH))); // R2

  AST_GAP_LOW: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    (slotIdx >= SLOT_W'(NUM_LEDS)) |=> !serialOut); // R5

  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    !serialOut |-> (lowRun < 32'(MAX_LOW))); // R5

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    slotIdx < SLOT_W'(NUM_LEDS + RESET_SLOTS)); // R6
endmodule

bind ledchain_driver ledchain_checker #(
  .NUM_LEDS(NUM_LEDS), .RESET_SLOTS(RESET_SLOTS), .WORD_BITS(WORD_BITS),
  .BIT_CYCLES(BIT_CYCLES), .ZERO_HIGH(ZERO_HIGH), .ONE_HIGH(ONE_HIGH),
  .SLOT_W(SLOT_W)
) chk_i (
  .clk(clk), .rst(rst), .serialOut(serialOut), .slotIdx(slotIdx)
);

// File: tb/ledchain_driver_tb_top.sv
module ledchain_driver_tb_top;
  localparam int N  = 3;
  localparam int RS = 2;
  localparam int CB = 8;
  localparam int BC = 10;
  localparam int ZH = 3;
  localparam int OH = 7;
  localparam int WB = 3 * CB;
  localparam int SLOT_LEN  = WB * BC;
  localparam int FRAME_LEN = (N + RS) * SLOT_LEN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*WB-1:0] ledWords = '0;
  logic serialOut;

  int checks = 0, fails = 0;
  bit finished = 0;
  string focus = "";
  int pos = 0;
  logic [WB-1:0] snap = '0;
  bit bad = 0;
  int badAct = 0, badExp = 0, badCyc = 0;

  always #10 clk = ~clk;

  ledchain_driver #(
    .NUM_LEDS(N), .RESET_SLOTS(RS), .COLOR_BITS(CB),
    .BIT_CYCLES(BC), .ZERO_HIGH(ZH), .ONE_HIGH(OH)
  ) dut_i (
    .clk(clk), .rst(rst), .ledWords(ledWords), .serialOut(serialOut)
  );

  function automatic logic [WB-1:0] wordOf(int i);
    return ledWords[i*WB +: WB];
  endfunction

  function automatic logic expHigh(int c, logic v);
    return (c < (v ? OH : ZH));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One clock: observe at the falling edge, compare with the waveform model
  task automatic tick();
    @(negedge clk);
    if (rst) begin
      check(serialOut === 1'b0, "R8", "output during reset", int'(serialOut), 0);
      pos = 0;
      bad = 0;
    end else begin
      int p, slot, b, c;
      logic v, e;
      string tag;
      p    = pos % FRAME_LEN;
      slot = p / SLOT_LEN;
      b    = (p % SLOT_LEN) / BC;
      c    = p % BC;
      if (slot < N) begin
        if (p % SLOT_LEN == 0) snap = wordOf(slot);
        v = snap[WB-1-b];
        e = expHigh(c, v);
      end else begin
        v = 1'b0;
        e = 1'b0;
      end
      if (serialOut !== e && !bad) begin
        bad = 1; badAct = int'(serialOut); badExp = int'(e); badCyc = c;
      end
      if (focus != "") tag = focus;
      else if (slot >= N) tag = "R5";
      else if (pos >= FRAME_LEN && p < SLOT_LEN) tag = "R6";
      else tag = v ? "R1" : "R2";
      if (slot < N && c == BC - 1) begin
        check(!bad, tag, $sformatf("led %0d bit %0d cycle %0d", slot, WB-1-b, badCyc),
              badAct, badExp);
        bad = 0;
      end else if (slot >= N && (p % SLOT_LEN) == SLOT_LEN - 1) begin
        check(!bad, "R5", $sformatf("gap slot %0d cycle %0d", slot, badCyc), badAct, badExp);
        bad = 0;
      end
      pos++;
    end
  endtask

  task automatic runFrames(int n);
    repeat (n * FRAME_LEN) tick();
  endtask

  task automatic runTo(int target);
    while (pos % FRAME_LEN != target) tick();
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1;
    repeat (4) tick();
    rst = 1'b0;

    // R2: all-zero words
    focus = "R2";
    runFrames(1);
    // R1: all-one words
    focus = "R1";
    ledWords = '1;
    runFrames(1);
    // R3: green-only, red-only, blue-only words check byte placement
    focus = "R3";
    ledWords = {24'h0000C5, 24'h00A300, 24'h960000};
    runFrames(1);
    // R4: distinct per-LED words check LED order
    focus = "R4";
    for (int i = 0; i < N; i++)
      ledWords[i*WB +: WB] = {8'(i + 1), 8'(16 * (i + 1)), 8'hC3};
    runFrames(1);
    // R7: change LED 1's word in the middle of its slot
    focus = "R7";
    ledWords = {24'h123456, 24'hF0F00F, 24'h5A5A5A};
    runTo(SLOT_LEN + 5 * BC + 3);
    ledWords[WB +: WB] = ~ledWords[WB +: WB];
    runTo(0);
    focus = "";
    runFrames(1);

    // Random words, rewritten at random moments (R6 repeats)
    for (int k = 0; k < 4 * FRAME_LEN; k++) begin
      tick();
      if ($urandom_range(199) == 0)
        ledWords[$urandom_range(N-1)*WB +: WB] = WB'($urandom);
    end

    // R8: reset in the middle of a frame, then restart from LED 0
    runTo(2 * SLOT_LEN + 7 * BC + 4);
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    focus = "R8";
    runFrames(1);
    focus = "";
    runFrames(1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule